// File: doc/BRIEF.md
# Dual Time-of-Day Alarm and Interrupt/Square-Wave Output Controller

This block sits beside the timekeeping counters of a clock/calendar. On every once-per-second update strobe it compares the current seconds, minutes, hours, weekday and date against two programmable alarm register sets. Each alarm field carries a mask bit in bit 7, and the combination of mask bits sets how often the alarm repeats. A bit in each alarm's day/date field selects whether that field is compared with the weekday or with the date. When an alarm matches, its flag-set pulse fires and its sticky flag is raised. The host clears a flag with a one-cycle clear strobe.

The shared output pin is open-drain. In interrupt mode it is pulled low while an enabled alarm flag is set. In square-wave mode it carries one of four frequencies derived from a 32.768 kHz reference waveform. When the block runs from backup power, the pin is released unless battery-backed output is enabled.

Top module: `tod_alarm_out`

## Requirements
- R1: Alarm 1 with all four mask bits set (seconds, minutes, hours, day/date bit 7 = 1111) fires on every update strobe.
- R2: Alarm 1 mask patterns 1110, 1100 and 1000 (day/date, hours, minutes, seconds masks) fire when the seconds, the seconds and minutes, or the seconds, minutes and hours (bits 6:0) match, respectively.
- R3: Alarm 1 pattern 0000 also requires a day/date match. Bit 6 of the day/date alarm field at 1 compares bits 5:0 with the weekday, and at 0 compares them with the date. Alarm 2 with pattern 000 applies the same rule.
- R4: Alarm 2 has no seconds field and fires only when the seconds (bits 6:0) equal 00. Its masks (day/date, hours, minutes) select 111 once per minute, 110 with a minutes match, and 100 with a minutes and hours match.
- R5: Mask combinations that are not listed in R1 to R4 never fire.
- R6: Comparison happens only in a cycle where the update strobe is high. The corresponding set pulse is high for exactly the next cycle.
- R7: A flag rises together with its set pulse and stays set until its clear strobe is high. A set and a clear in the same cycle leave the flag set.
- R8: With the mode select at 1 (interrupt mode), the pin pull-low output is 1 exactly while (flag1 and enable1) or (flag2 and enable2) holds.
- R9: With the mode select at 0, the pin carries a 50%-duty square wave. Rate select 00 gives a half period of 16384 reference rising edges, 01 gives 4, 10 gives 2, and 11 follows the registered reference itself. The pin is pulled low during the low phase.
- R10: While on backup power with the battery-output enable at 0, the pull-low output is 0 (pin released). With the enable at 1 the pin behaves as in R8 and R9.
- R11: After reset both flags and both set pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle once-per-second update strobe; time inputs already hold the new time |
| timeSec | input | 8 | Current seconds, BCD |
| timeMin | input | 8 | Current minutes, BCD |
| timeHour | input | 8 | Current hours, with format bits |
| timeDow | input | 8 | Current weekday 1..7 |
| timeDate | input | 8 | Current date, BCD |
| a1Sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1Min | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1Hour | input | 8 | Alarm 1 hours, bit 7 mask |
| a1DayDate | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 weekday select |
| a2Min | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2Hour | input | 8 | Alarm 2 hours, bit 7 mask |
| a2DayDate | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 weekday select |
| intMode | input | 1 | 1 interrupt mode, 0 square-wave mode |
| rateSel | input | 2 | Square-wave rate select |
| a1IrqEn | input | 1 | Alarm 1 interrupt enable |
| a2IrqEn | input | 1 | Alarm 2 interrupt enable |
| battSqEn | input | 1 | Keep pin active while on backup power |
| onBackup | input | 1 | Running from backup supply |
| refWave | input | 1 | 32.768 kHz reference waveform, synchronous to clk |
| clrFlag1 | input | 1 | Clear strobe for alarm 1 flag |
| clrFlag2 | input | 1 | Clear strobe for alarm 2 flag |
| a1SetPulse | output | 1 | Alarm 1 flag-set pulse |
| a2SetPulse | output | 1 | Alarm 2 flag-set pulse |
| a1Flag | output | 1 | Alarm 1 sticky flag |
| a2Flag | output | 1 | Alarm 2 sticky flag |
| pinPullLow | output | 1 | 1 pulls the open-drain pin low |

## Verification
The assertions assume that the update strobe is a single-cycle pulse, that the reference waveform is already synchronous to clk and stays high or low for at least one clock, and that alarm and time hours share the same 12/24-hour format. The stimulus drives every input half a cycle away from the sampling edge. It raises the strobe for one cycle at a time, toggles the reference once per clock, and copies the time's format bits into the alarm hours through the same BCD generator. Random alarm contents are biased toward copies of the current time so that every mask pattern, including unlisted ones, produces both hits and misses.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW  = 2'b00,
    RATE_4K    = 2'b01,
    RATE_8K    = 2'b10,
    RATE_FULL  = 2'b11
  } rate_e;

  // strobes and levels the control half hands to the output datapath
  typedef struct packed {
    logic  irqReq;
    logic  intMode;
    logic  outEn;
    rate_e rate;
  } ctl2dp_t;

endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
  parameter bit HAS_SEC = 1'b1,
  parameter int FW      = 8
) (
  input  logic [FW-1:0] timeSec,
  input  logic [FW-1:0] timeMin,
  input  logic [FW-1:0] timeHour,
  input  logic [FW-1:0] timeDow,
  input  logic [FW-1:0] timeDate,
  input  logic [FW-1:0] alSec,
  input  logic [FW-1:0] alMin,
  input  logic [FW-1:0] alHour,
  input  logic [FW-1:0] alDayDate,
  output logic          hit
);
  localparam int MB = FW - 1;   // mask bit
  localparam int SB = FW - 2;   // weekday select bit

  logic [FW-1:0] effSec;
  logic [3:0]    maskPat;
  logic          eqSec, eqMin, eqHour, eqDd;
  logic [FW-1:0] ddRef;

  generate
    if (HAS_SEC) begin : g_sec
      assign effSec = alSec;
    end else begin : g_nosec
      // without a seconds field the alarm behaves as seconds = 00, unmasked
      assign effSec = '0;
    end
  endgenerate

  assign maskPat = {alDayDate[MB], alHour[MB], alMin[MB], effSec[MB]};
  assign ddRef   = alDayDate[SB] ? timeDow : timeDate;

  assign eqSec  = (timeSec[SB:0]  == effSec[SB:0]);
  assign eqMin  = (timeMin[SB:0]  == alMin[SB:0]);
  assign eqHour = (timeHour[SB:0] == alHour[SB:0]);
  assign eqDd   = (ddRef[SB-1:0]  == alDayDate[SB-1:0]);

  always_comb begin
    unique case (maskPat)
      4'b1111: hit = 1'b1;
      4'b1110: hit = eqSec;
      4'b1100: hit = eqSec & eqMin;
      4'b1000: hit = eqSec & eqMin & eqHour;
      4'b0000: hit = eqSec & eqMin & eqHour & eqDd;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tod_alarm_ctl.sv
module tod_alarm_ctl
  import tod_alarm_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          secTick,
  input  logic [FW-1:0] timeSec,
  input  logic [FW-1:0] timeMin,
  input  logic [FW-1:0] timeHour,
  input  logic [FW-1:0] timeDow,
  input  logic [FW-1:0] timeDate,
  input  logic [FW-1:0] a1Sec,
  input  logic [FW-1:0] a1Min,
  input  logic [FW-1:0] a1Hour,
  input  logic [FW-1:0] a1DayDate,
  input  logic [FW-1:0] a2Min,
  input  logic [FW-1:0] a2Hour,
  input  logic [FW-1:0] a2DayDate,
  input  logic          intMode,
  input  logic [1:0]    rateSel,
  input  logic          a1IrqEn,
  input  logic          a2IrqEn,
  input  logic          battSqEn,
  input  logic          onBackup,
  input  logic          clrFlag1,
  input  logic          clrFlag2,
  output logic          a1SetPulse,
  output logic          a2SetPulse,
  output logic          a1Flag,
  output logic          a2Flag,
  output ctl2dp_t       toDp
);
  localparam int MB = FW - 1;
  localparam int NA = 2;

  logic [NA-1:0] match, fire, flagQ, pulseQ, clr;
  logic [FW-1:0] alSecV [NA];
  logic [FW-1:0] alMinV [NA];
  logic [FW-1:0] alHourV[NA];
  logic [FW-1:0] alDdV  [NA];

  assign alSecV[0]  = a1Sec;     assign alSecV[1]  = '0;
  assign alMinV[0]  = a1Min;     assign alMinV[1]  = a2Min;
  assign alHourV[0] = a1Hour;    assign alHourV[1] = a2Hour;
  assign alDdV[0]   = a1DayDate; assign alDdV[1]   = a2DayDate;
  assign clr        = {clrFlag2, clrFlag1};

  generate
    for (genvar i = 0; i < NA; i++) begin : g_alarm
      tod_alarm_match #(.HAS_SEC(i == 0), .FW(FW)) u_match (
        .timeSec  (timeSec),
        .timeMin  (timeMin),
        .timeHour (timeHour),
        .timeDow  (timeDow),
        .timeDate (timeDate),
        .alSec    (alSecV[i]),
        .alMin    (alMinV[i]),
        .alHour   (alHourV[i]),
        .alDayDate(alDdV[i]),
        .hit      (match[i])
      );

      assign fire[i] = secTick & match[i];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          flagQ[i]  <= 1'b0;
          pulseQ[i] <= 1'b0;
        end else begin
          pulseQ[i] <= fire[i];
          // a set in the same cycle as a clear wins
          flagQ[i]  <= (flagQ[i] & ~clr[i]) | fire[i];
        end
      end
    end
  endgenerate

  assign a1SetPulse = pulseQ[0];
  assign a2SetPulse = pulseQ[1];
  assign a1Flag     = flagQ[0];
  assign a2Flag     = flagQ[1];

  assign toDp.irqReq  = (flagQ[0] & a1IrqEn) | (flagQ[1] & a2IrqEn);
  assign toDp.intMode = intMode;
  assign toDp.outEn   = ~onBackup | battSqEn;
  assign toDp.rate    = rate_e'(rateSel);

  // independent decode of which alarm-1 mask patterns are allowed to fire
  logic [3:0] a1Pat;
  logic       a1Listed;
  assign a1Pat    = {a1DayDate[MB], a1Hour[MB], a1Min[MB], a1Sec[MB]};
  assign a1Listed = (a1Pat == 4'hF) || (a1Pat == 4'hE) || (a1Pat == 4'hC) ||
                    (a1Pat == 4'h8) || (a1Pat == 4'h0);

  a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    (a1SetPulse || a2SetPulse) |-> $past(secTick));

  a_r4_second_zero: assert property (@(posedge clk) disable iff (!rstN)
    a2SetPulse |-> ($past(timeSec[MB-1:0]) == '0));

  a_r5_listed_only: assert property (@(posedge clk) disable iff (!rstN)
    a1SetPulse |-> $past(a1Listed));

  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(a1Flag) |-> $past(clrFlag1));

  a_r7_fall_needs_clear2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(a2Flag) |-> $past(clrFlag2));
endmodule

// File: rtl/tod_sqw_dp.sv
module tod_sqw_dp
  import tod_alarm_pkg::*;
#(
  parameter int DIV_W = 15   // log2 of the reference rate
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    refWave,
  input  ctl2dp_t fromCtl,
  output logic    pinPullLow
);
  localparam int IDX_SLOW = DIV_W - 1;
  localparam int IDX_4K   = 2;
  localparam int IDX_8K   = 1;

  logic             refQ, refRise, sqLevel;
  logic [DIV_W-1:0] divCnt;

  assign refRise = refWave & ~refQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ   <= 1'b0;
      divCnt <= '0;
    end else begin
      refQ <= refWave;
      if (refRise) divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (fromCtl.rate)
      RATE_SLOW: sqLevel = divCnt[IDX_SLOW];
      RATE_4K:   sqLevel = divCnt[IDX_4K];
      RATE_8K:   sqLevel = divCnt[IDX_8K];
      default:   sqLevel = refQ;
    endcase
  end

  assign pinPullLow = fromCtl.outEn &
                      (fromCtl.intMode ? fromCtl.irqReq : ~sqLevel);

  a_r9_count_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$past(refRise) |-> $stable(divCnt));
endmodule

// File: rtl/tod_alarm_out.sv
module tod_alarm_out
  import tod_alarm_pkg::*;
#(
  parameter int FW    = 8,
  parameter int DIV_W = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          secTick,
  input  logic [FW-1:0] timeSec,
  input  logic [FW-1:0] timeMin,
  input  logic [FW-1:0] timeHour,
  input  logic [FW-1:0] timeDow,
  input  logic [FW-1:0] timeDate,
  input  logic [FW-1:0] a1Sec,
  input  logic [FW-1:0] a1Min,
  input  logic [FW-1:0] a1Hour,
  input  logic [FW-1:0] a1DayDate,
  input  logic [FW-1:0] a2Min,
  input  logic [FW-1:0] a2Hour,
  input  logic [FW-1:0] a2DayDate,
  input  logic          intMode,
  input  logic [1:0]    rateSel,
  input  logic          a1IrqEn,
  input  logic          a2IrqEn,
  input  logic          battSqEn,
  input  logic          onBackup,
  input  logic          refWave,
  input  logic          clrFlag1,
  input  logic          clrFlag2,
  output logic          a1SetPulse,
  output logic          a2SetPulse,
  output logic          a1Flag,
  output logic          a2Flag,
  output logic          pinPullLow
);
  ctl2dp_t ctlBus;

  tod_alarm_ctl #(.FW(FW)) u_ctl (
    .clk, .rstN, .secTick,
    .timeSec, .timeMin, .timeHour, .timeDow, .timeDate,
    .a1Sec, .a1Min, .a1Hour, .a1DayDate,
    .a2Min, .a2Hour, .a2DayDate,
    .intMode, .rateSel, .a1IrqEn, .a2IrqEn, .battSqEn, .onBackup,
    .clrFlag1, .clrFlag2,
    .a1SetPulse, .a2SetPulse, .a1Flag, .a2Flag,
    .toDp(ctlBus)
  );

  tod_sqw_dp #(.DIV_W(DIV_W)) u_dp (
    .clk, .rstN, .refWave,
    .fromCtl(ctlBus),
    .pinPullLow
  );

  a_r10_backup_release: assert property (@(posedge clk) disable iff (!rstN)
    (onBackup && !battSqEn) |-> !pinPullLow);

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && !onBackup) |-> (pinPullLow == ((a1Flag && a1IrqEn) || (a2Flag && a2IrqEn))));
endmodule

// File: tb/sim_tod_alarm_out.sv
module sim_tod_alarm_out;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, secTick = 1'b0;
  logic [7:0] timeSec = 0, timeMin = 0, timeHour = 0, timeDow = 8'd1, timeDate = 8'd1;
  logic [7:0] a1Sec = 0, a1Min = 0, a1Hour = 0, a1DayDate = 0;
  logic [7:0] a2Min = 0, a2Hour = 0, a2DayDate = 0;
  logic intMode = 1'b1, a1IrqEn = 1'b0, a2IrqEn = 1'b0, battSqEn = 1'b0, onBackup = 1'b0;
  logic [1:0] rateSel = 2'b11;
  logic refWave = 1'b0, clrFlag1 = 1'b0, clrFlag2 = 1'b0;
  logic a1SetPulse, a2SetPulse, a1Flag, a2Flag, pinPullLow;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  bit ef1 = 1'b0, ef2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) refWave <= ~refWave;

  tod_alarm_out u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) << 4 | (v % 10));
  endfunction

  function automatic bit expA1();
    bit s, m, h, d;
    logic [3:0] p;
    s = timeSec[6:0] == a1Sec[6:0];
    m = timeMin[6:0] == a1Min[6:0];
    h = timeHour[6:0] == a1Hour[6:0];
    d = a1DayDate[6] ? (timeDow[5:0] == a1DayDate[5:0]) : (timeDate[5:0] == a1DayDate[5:0]);
    p = {a1DayDate[7], a1Hour[7], a1Min[7], a1Sec[7]};
    case (p)
      4'b1111: return 1'b1;
      4'b1110: return s;
      4'b1100: return s & m;
      4'b1000: return s & m & h;
      4'b0000: return s & m & h & d;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expA2();
    bit z, m, h, d;
    logic [2:0] p;
    z = timeSec[6:0] == 7'd0;
    m = timeMin[6:0] == a2Min[6:0];
    h = timeHour[6:0] == a2Hour[6:0];
    d = a2DayDate[6] ? (timeDow[5:0] == a2DayDate[5:0]) : (timeDate[5:0] == a2DayDate[5:0]);
    p = {a2DayDate[7], a2Hour[7], a2Min[7]};
    case (p)
      3'b111: return z;
      3'b110: return z & m;
      3'b100: return z & m & h;
      3'b000: return z & m & h & d;
      default: return 1'b0;
    endcase
  endfunction

  // one update strobe; the time and alarm inputs are already applied
  task automatic strobe(input bit withClr1, input string tag);
    bit e1, e2;
    @(negedge clk);
    e1 = expA1(); e2 = expA2();
    secTick = 1'b1; clrFlag1 = withClr1;
    @(negedge clk);
    secTick = 1'b0; clrFlag1 = 1'b0;
    chk({tag, " R6 pulse1"}, a1SetPulse, e1);
    chk({tag, " R6 pulse2"}, a2SetPulse, e2);
    ef1 = (ef1 & ~withClr1) | e1;
    ef2 = ef2 | e2;
    chk({tag, " R7 flag1"}, a1Flag, ef1);
    chk({tag, " R7 flag2"}, a2Flag, ef2);
    @(negedge clk);
    chk({tag, " R6 pulse1 one cycle"}, a1SetPulse, 1'b0);
    chk({tag, " R6 pulse2 one cycle"}, a2SetPulse, 1'b0);
  endtask

  task automatic clearFlags(input bit c1, input bit c2);
    @(negedge clk);
    clrFlag1 = c1; clrFlag2 = c2;
    @(negedge clk);
    clrFlag1 = 1'b0; clrFlag2 = 1'b0;
    if (c1) ef1 = 1'b0;
    if (c2) ef2 = 1'b0;
    chk("R7 flag1 after clear", a1Flag, ef1);
    chk("R7 flag2 after clear", a2Flag, ef2);
  endtask

  task automatic randTime();
    timeSec  = bcd($urandom % 60);
    timeMin  = bcd($urandom % 60);
    timeHour = bcd($urandom % 24);
    timeDow  = 8'(1 + $urandom % 7);
    timeDate = bcd(1 + $urandom % 31);
    if ($urandom % 3 == 0) timeSec = 8'h00;
  endtask

  function automatic logic [7:0] pick(input logic [7:0] t, input logic [7:0] r);
    return ($urandom % 10 < 7) ? t : r;
  endfunction

  // measure a half period of the pin, then the next one
  task automatic measure(input logic [1:0] rs, input int half, input string tag);
    int n;
    logic prev;
    rateSel = rs;
    repeat (3) @(negedge clk);
    prev = pinPullLow;
    n = 0;
    while (pinPullLow == prev && n < 40000) begin @(negedge clk); n++; end
    for (int k = 0; k < 2; k++) begin
      prev = pinPullLow;
      n = 0;
      while (pinPullLow == prev && n < 40000) begin @(negedge clk); n++; end
      chk(tag, n, half);
    end
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset flag1", a1Flag, 0);
    chk("R11 reset flag2", a2Flag, 0);
    chk("R11 reset pulse1", a1SetPulse, 0);
    chk("R11 reset pulse2", a2SetPulse, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: all masks set fires every update
    a1Sec = 8'h80; a1Min = 8'h80; a1Hour = 8'h80; a1DayDate = 8'h80;
    a2Min = 8'h00; a2Hour = 8'h00; a2DayDate = 8'h3F;
    timeSec = 8'h17;
    strobe(0, "R1 every second");
    timeSec = 8'h18;
    strobe(0, "R1 next second");

    // R6: matching alarm without a strobe does nothing
    clearFlags(1, 1);
    repeat (4) @(negedge clk);
    chk("R6 no strobe no pulse", a1SetPulse, 0);
    chk("R6 no strobe flag", a1Flag, 0);

    // R7: set and clear together leave flag set
    strobe(1, "R7 set wins");
    chk("R7 set wins over clear", a1Flag, 1);

    // R2 directed: minutes+seconds
    clearFlags(1, 1);
    timeSec = 8'h30; timeMin = 8'h45; timeHour = 8'h12;
    a1Sec = 8'h30; a1Min = 8'h45; a1Hour = 8'h80; a1DayDate = 8'h80;
    strobe(0, "R2 min sec match");
    a1Min = 8'h44;
    strobe(0, "R2 min miss");

    // R3: weekday vs date select
    clearFlags(1, 1);
    timeDow = 8'd3; timeDate = 8'h21;
    a1Min = 8'h45; a1Hour = 8'h12; a1DayDate = 8'h43;
    strobe(0, "R3 weekday match");
    clearFlags(1, 0);
    a1DayDate = 8'h03;
    strobe(0, "R3 date miss");
    a1DayDate = 8'h21;
    strobe(0, "R3 date match");

    // R4: alarm 2 only at second 00
    clearFlags(1, 1);
    a2Min = 8'h80; a2Hour = 8'h80; a2DayDate = 8'h80;
    timeSec = 8'h01;
    strobe(0, "R4 a2 not zero");
    timeSec = 8'h00;
    strobe(0, "R4 a2 at zero");

    // R5: unlisted combo never fires
    clearFlags(1, 1);
    a1Sec = 8'h00; a1Min = 8'h80; a1Hour = 8'h00; a1DayDate = 8'h80;
    a2Min = 8'h80; a2Hour = 8'h00; a2DayDate = 8'h80;
    strobe(0, "R5 unlisted");

    // random mix; checks R1-R5 via model, R8 at the pin
    for (int it = 0; it < 300; it++) begin
      logic [3:0] m1;
      logic [2:0] m2;
      randTime();
      m1 = ($urandom % 4 == 0) ? 4'($urandom) : 4'(4'hF << ($urandom % 5));
      m2 = ($urandom % 4 == 0) ? 3'($urandom) : 3'(3'h7 << ($urandom % 4));
      a1Sec     = {m1[0], pick(timeSec, bcd($urandom % 60))    [6:0]};
      a1Min     = {m1[1], pick(timeMin, bcd($urandom % 60))    [6:0]};
      a1Hour    = {m1[2], pick(timeHour, bcd($urandom % 24))   [6:0]};
      a2Min     = {m2[0], pick(timeMin, bcd($urandom % 60))    [6:0]};
      a2Hour    = {m2[1], pick(timeHour, bcd($urandom % 24))   [6:0]};
      if ($urandom % 2) begin
        a1DayDate = {m1[3], 1'b1, pick(timeDow, 8'(1 + $urandom % 7))[5:0]};
        a2DayDate = {m2[2], 1'b1, pick(timeDow, 8'(1 + $urandom % 7))[5:0]};
      end else begin
        a1DayDate = {m1[3], 1'b0, pick(timeDate, bcd(1 + $urandom % 31))[5:0]};
        a2DayDate = {m2[2], 1'b0, pick(timeDate, bcd(1 + $urandom % 31))[5:0]};
      end
      a1IrqEn = 1'($urandom); a2IrqEn = 1'($urandom);
      strobe(0, "R2 R3 R4 R5 random");
      chk("R8 irq pin", pinPullLow, (ef1 & a1IrqEn) | (ef2 & a2IrqEn));
      clearFlags(1'($urandom), 1'($urandom));
      chk("R8 irq pin after clear", pinPullLow, (ef1 & a1IrqEn) | (ef2 & a2IrqEn));
    end

    // R10: backup gating with flag1 raised and enabled
    clearFlags(1, 1);
    a1Sec = 8'h80; a1Min = 8'h80; a1Hour = 8'h80; a1DayDate = 8'h80;
    strobe(0, "R10 setup");
    a1IrqEn = 1'b1; onBackup = 1'b1; battSqEn = 1'b0;
    @(negedge clk);
    chk("R10 released on backup", pinPullLow, 0);
    battSqEn = 1'b1;
    @(negedge clk);
    chk("R10 active on backup", pinPullLow, 1);
    onBackup = 1'b0; battSqEn = 1'b0;

    // R9: square-wave half periods in clk cycles (one reference rise per two clocks)
    intMode = 1'b0;
    measure(2'b11, 1, "R9 rate 11");
    measure(2'b10, 4, "R9 rate 10");
    measure(2'b01, 8, "R9 rate 01");
    measure(2'b00, 32768, "R9 rate 00");
    onBackup = 1'b1;
    repeat (20) begin
      @(negedge clk);
      chk("R10 square wave released", pinPullLow, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired before the end of the run");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule